// File: doc/BRIEF.md
# Per-Thread In-Order Issue Front End

This block is the front end of one hardware thread inside a multithreaded superscalar core. It asks the instruction cache for a whole aligned line of four 32-bit words and keeps that line in a local fetch buffer. It then walks the line one word at a time in program order. Each decoded instruction is held at decode until every source register it names has no write outstanding. A per-register pending-write scoreboard tracks those writes. Once the sources are free, the instruction moves into a one-entry issue buffer, which offers it to the shared issue unit through a valid/ready handshake.

Unconditional PC-relative jumps need no register operands. The block resolves them itself with its own target adder. A jump discards the rest of the current line and requests the line that holds the target. Jumps are never offered to the issue unit. Two writeback ports report completed register writes and clear scoreboard entries. Both ports may carry results for this thread in the same cycle.

The instruction cache, the execution units and the register data storage sit outside this block. The instruction format uses fixed fields, as given in R11.

Top module: `thr_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, the block invalidates both buffers and clears every pending bit. After reset it holds `fetch_req_valid` high with `fetch_req_addr` equal to `rst_pc` with its low 4 bits cleared. It keeps `iss_valid` low, and decoding starts at word `rst_pc[3:2]` of the returned line.
- R2: A line request stays asserted with a stable address until `fetch_rsp_valid` is seen. The response loads all four words at once, word k taken from `fetch_rsp_line[32k+31:32k]`. No new request is raised while the line is held.
- R3: Instructions are offered in program order. `iss_pc` equals the line address plus 4 times the word index. When word 3 of a line has been consumed without a jump, the next request is for the line address plus 16, and decoding starts at word 0.
- R4: While the fetch buffer holds no line, nothing new enters the issue buffer.
- R5: An instruction whose source register has a pending write waits at decode, and no younger instruction passes it. It enters the issue buffer on the edge after the edge at which the last pending source is cleared.
- R6: When an instruction that writes rd (rd not 0) enters the issue buffer, the pending bit of rd is set. A writeback on port 0 or port 1 clears the bit of its register, and both ports may clear different registers in the same cycle.
- R7: If a set and a writeback clear of the same register fall on the same edge, the register stays pending.
- R8: Register 0 is never pending. Instructions that read it never wait for it, and writes to it set no pending bit.
- R9: Opcode 4 is a local jump to the word's PC plus 4 times the sign-extended 13-bit immediate. It is never offered to the issue unit. The remaining words of its line are discarded. The next request goes to the target with its low 4 bits cleared, and decoding starts at word target[3:2].
- R10: The issue buffer holds one entry. While `iss_valid` is high and `iss_ready` is low, the entry stays unchanged and decoding stalls. An entry leaves on an edge where both are high.
- R11: The instruction fields are: opcode [31:28], rd [27:23], rs1 [22:18], rs2 [17:13] and imm [12:0]. Opcode 1 reads rs1 and rs2 and writes rd. Opcode 2 reads rs1 and writes rd. Opcode 3 reads rs1 and rs2 and writes nothing. Any other code except 4 is issued with no sources and no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pc | input | 32 | Program counter used at reset |
| fetch_req_valid | output | 1 | Line request outstanding |
| fetch_req_addr | output | 32 | Line-aligned request address |
| fetch_rsp_valid | input | 1 | Line data returned this cycle |
| fetch_rsp_line | input | 128 | Four instruction words, word 0 in the low bits |
| iss_valid | output | 1 | Issue buffer holds an instruction |
| iss_ready | input | 1 | Issue unit accepts the held instruction |
| iss_pc | output | 32 | PC of the held instruction |
| iss_instr | output | 32 | Held instruction word |
| wb0_valid | input | 1 | Writeback port 0 completion |
| wb0_reg | input | 5 | Register completed on port 0 |
| wb1_valid | input | 1 | Writeback port 1 completion |
| wb1_reg | input | 5 | Register completed on port 1 |

## Verification
The bench first enters a line at a middle word, then takes forward and backward jumps. If the start offset or the immediate's sign extension were wrong, the wrong request address would appear or stray words would be issued. It holds a dependent instruction behind an independent younger one. It also sends a writeback for an unrelated register and then a pair of writebacks on both ports in one cycle. A design that let instructions pass, cleared the wrong bit, or honoured only one port would issue too early or never. It lines up a writeback with the issuing edge of the same register's writer, to catch a clear that beats the set. It stalls the issue unit to show the held entry stays stable. In that same test a write to register 0 is followed by a read of it, which must not stall.

// File: rtl/thr_fe_pkg.sv
package thr_fe_pkg;

    localparam int XLEN        = 32;
    localparam int LINE_WORDS  = 4;
    localparam int NUM_REGS    = 32;
    localparam int IMM_W       = 13;
    localparam int BYTE_OFF_W  = $clog2(XLEN / 8);
    localparam int WIDX_W      = $clog2(LINE_WORDS);
    localparam int OFF_W       = WIDX_W + BYTE_OFF_W;
    localparam int TAG_W       = XLEN - OFF_W;
    localparam int LINE_BITS   = XLEN * LINE_WORDS;
    localparam int REG_W       = $clog2(NUM_REGS);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ALU   = 4'd1,
        OP_ALUI  = 4'd2,
        OP_STORE = 4'd3,
        OP_JMP   = 4'd4
    } opcode_e;

    typedef struct packed {
        logic [3:0]       op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef struct packed {
        logic use_rs1;
        logic use_rs2;
        logic wr_rd;
        logic is_jump;
    } dec_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        instr_t          ins;
    } issue_pkt_t;

    function automatic dec_ctl_t decode_ctl(input instr_t ins);
        dec_ctl_t c;
        c = '0;
        case (ins.op)
            4'(OP_ALU):   begin c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; c.wr_rd = 1'b1; end
            4'(OP_ALUI):  begin c.use_rs1 = 1'b1; c.wr_rd = 1'b1; end
            4'(OP_STORE): begin c.use_rs1 = 1'b1; c.use_rs2 = 1'b1; end
            4'(OP_JMP):   c.is_jump = 1'b1;
            default:      c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                    input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] offs;
        offs = {{(XLEN-IMM_W-BYTE_OFF_W){imm[IMM_W-1]}}, imm, {BYTE_OFF_W{1'b0}}};
        return pc + offs;
    endfunction

endpackage

// File: rtl/thr_fe_linebuf.sv
module thr_fe_linebuf
    import thr_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [XLEN-1:0]      rst_pc,
    input  logic                 rsp_valid,
    input  logic [LINE_BITS-1:0] rsp_line,
    input  logic                 advance,
    input  logic                 redirect,
    input  logic [XLEN-1:0]      redirect_pc,
    output logic                 req_valid,
    output logic [XLEN-1:0]      req_addr,
    output logic                 word_valid,
    output logic [XLEN-1:0]      word_data,
    output logic [XLEN-1:0]      word_pc
);

    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(LINE_WORDS - 1);

    logic [LINE_BITS-1:0] line_q;
    logic                 line_vld_q;
    logic                 req_pend_q;
    logic [TAG_W-1:0]     req_tag_q;
    logic [TAG_W-1:0]     cur_tag_q;
    logic [WIDX_W-1:0]    widx_q;
    logic [XLEN-1:0]      words [LINE_WORDS];

    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word
        assign words[k] = line_q[k*XLEN +: XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q     <= '0;
            line_vld_q <= 1'b0;
            req_pend_q <= 1'b1;
            req_tag_q  <= rst_pc[XLEN-1:OFF_W];
            cur_tag_q  <= '0;
            widx_q     <= rst_pc[OFF_W-1:BYTE_OFF_W];
        end else if (req_pend_q && rsp_valid) begin
            line_q     <= rsp_line;
            line_vld_q <= 1'b1;
            req_pend_q <= 1'b0;
            cur_tag_q  <= req_tag_q;
        end else if (line_vld_q && advance) begin
            if (redirect) begin
                line_vld_q <= 1'b0;
                req_pend_q <= 1'b1;
                req_tag_q  <= redirect_pc[XLEN-1:OFF_W];
                widx_q     <= redirect_pc[OFF_W-1:BYTE_OFF_W];
            end else if (widx_q == LAST_IDX) begin
                line_vld_q <= 1'b0;
                req_pend_q <= 1'b1;
                req_tag_q  <= cur_tag_q + 1'b1;
                widx_q     <= '0;
            end else begin
                widx_q     <= widx_q + 1'b1;
            end
        end
    end

    logic unused_lowbits;
    assign unused_lowbits = ^{rst_pc[BYTE_OFF_W-1:0], redirect_pc[BYTE_OFF_W-1:0]};

    assign req_valid  = req_pend_q;
    assign req_addr   = {req_tag_q, {OFF_W{1'b0}}};
    assign word_valid = line_vld_q;
    assign word_data  = words[widx_q];
    assign word_pc    = {cur_tag_q, widx_q, {BYTE_OFF_W{1'b0}}};

    // R2
    req_vs_line_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !word_valid);

endmodule

// File: rtl/thr_fe_scoreboard.sv
module thr_fe_scoreboard
    import thr_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    output logic             busy_a,
    output logic             busy_b,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic             clr0_en,
    input  logic [REG_W-1:0] clr0_reg,
    input  logic             clr1_en,
    input  logic [REG_W-1:0] clr1_reg
);

    logic [NUM_REGS-1:0] busy_vec;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign busy_vec[r] = 1'b0;
        end else begin : g_bit
            logic bit_q;
            logic set_hit;
            logic clr_hit;

            assign set_hit = set_en && (set_reg == REG_W'(r));
            assign clr_hit = (clr0_en && (clr0_reg == REG_W'(r))) ||
                             (clr1_en && (clr1_reg == REG_W'(r)));

            always_ff @(posedge clk) begin
                if (rst)          bit_q <= 1'b0;
                else if (set_hit) bit_q <= 1'b1;
                else if (clr_hit) bit_q <= 1'b0;
            end

            assign busy_vec[r] = bit_q;

            // R7
            set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (set_hit && clr_hit) |=> busy_vec[r]);

            // R6
            clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_hit && !set_hit) |=> !busy_vec[r]);
        end
    end

    assign busy_a = busy_vec[rd_a];
    assign busy_b = busy_vec[rd_b];

endmodule

// File: rtl/thr_fe_issue_q.sv
module thr_fe_issue_q
    import thr_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  issue_pkt_t load_pkt,
    output logic       free,
    output logic       out_valid,
    input  logic       out_ready,
    output issue_pkt_t out_pkt
);

    logic       vld_q;
    issue_pkt_t pkt_q;

    always_ff @(posedge clk) begin
        if (rst)            vld_q <= 1'b0;
        else if (load)      vld_q <= 1'b1;
        else if (out_ready) vld_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (load) pkt_q <= load_pkt;
    end

    assign free      = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_pkt   = pkt_q;

    // R10
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

endmodule

// File: rtl/thr_frontend.sv
module thr_frontend
    import thr_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [XLEN-1:0]      rst_pc,
    output logic                 fetch_req_valid,
    output logic [XLEN-1:0]      fetch_req_addr,
    input  logic                 fetch_rsp_valid,
    input  logic [LINE_BITS-1:0] fetch_rsp_line,
    output logic                 iss_valid,
    input  logic                 iss_ready,
    output logic [XLEN-1:0]      iss_pc,
    output logic [XLEN-1:0]      iss_instr,
    input  logic                 wb0_valid,
    input  logic [REG_W-1:0]     wb0_reg,
    input  logic                 wb1_valid,
    input  logic [REG_W-1:0]     wb1_reg
);

    logic            word_valid;
    logic [XLEN-1:0] word_data;
    logic [XLEN-1:0] word_pc;
    instr_t          cur;
    dec_ctl_t        ctl;
    logic            busy_a, busy_b;
    logic            srcs_ok;
    logic            q_free;
    logic            jump_go, issue_go, advance;
    logic [XLEN-1:0] target_pc;
    logic            set_en;
    issue_pkt_t      new_pkt, out_pkt;

    assign cur       = instr_t'(word_data);
    assign ctl       = decode_ctl(cur);
    assign srcs_ok   = !(ctl.use_rs1 && busy_a) && !(ctl.use_rs2 && busy_b);
    assign jump_go   = word_valid && ctl.is_jump;
    assign issue_go  = word_valid && !ctl.is_jump && srcs_ok && q_free;
    assign advance   = jump_go || issue_go;
    assign target_pc = jump_target(word_pc, cur.imm);
    assign set_en    = issue_go && ctl.wr_rd && (cur.rd != '0);
    assign new_pkt   = '{pc: word_pc, ins: cur};

    thr_fe_linebuf u_linebuf (
        .clk         (clk),
        .rst         (rst),
        .rst_pc      (rst_pc),
        .rsp_valid   (fetch_rsp_valid),
        .rsp_line    (fetch_rsp_line),
        .advance     (advance),
        .redirect    (jump_go),
        .redirect_pc (target_pc),
        .req_valid   (fetch_req_valid),
        .req_addr    (fetch_req_addr),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_pc     (word_pc)
    );

    thr_fe_scoreboard u_sb (
        .clk      (clk),
        .rst      (rst),
        .rd_a     (cur.rs1),
        .rd_b     (cur.rs2),
        .busy_a   (busy_a),
        .busy_b   (busy_b),
        .set_en   (set_en),
        .set_reg  (cur.rd),
        .clr0_en  (wb0_valid),
        .clr0_reg (wb0_reg),
        .clr1_en  (wb1_valid),
        .clr1_reg (wb1_reg)
    );

    thr_fe_issue_q u_iq (
        .clk       (clk),
        .rst       (rst),
        .load      (issue_go),
        .load_pkt  (new_pkt),
        .free      (q_free),
        .out_valid (iss_valid),
        .out_ready (iss_ready),
        .out_pkt   (out_pkt)
    );

    assign iss_pc    = out_pkt.pc;
    assign iss_instr = out_pkt.ins;

    // R5
    decode_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !advance) |=> (word_valid && $stable(word_pc) && $stable(word_data)));

endmodule

// File: tb/thr_frontend_tb.sv
`timescale 1ns/100ps
module thr_frontend_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [31:0]  rst_pc;
    logic         fetch_req_valid;
    logic [31:0]  fetch_req_addr;
    logic         fetch_rsp_valid;
    logic [127:0] fetch_rsp_line;
    logic         iss_valid;
    logic         iss_ready;
    logic [31:0]  iss_pc;
    logic [31:0]  iss_instr;
    logic         wb0_valid, wb1_valid;
    logic [4:0]   wb0_reg, wb1_reg;

    always #2.5 clk = ~clk;

    thr_frontend dut_i (
        .clk(clk), .rst(rst), .rst_pc(rst_pc),
        .fetch_req_valid(fetch_req_valid), .fetch_req_addr(fetch_req_addr),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_line(fetch_rsp_line),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_pc(iss_pc), .iss_instr(iss_instr),
        .wb0_valid(wb0_valid), .wb0_reg(wb0_reg),
        .wb1_valid(wb1_valid), .wb1_reg(wb1_reg)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc = 0;

    logic [31:0] log_pc  [64];
    logic [31:0] log_ins [64];
    int log_n = 0;

    always @(negedge clk) begin
        #2;
        if (!rst && iss_valid && iss_ready && log_n < 64) begin
            log_pc[log_n]  = iss_pc;
            log_ins[log_n] = iss_instr;
            log_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [4:0] rd,
                                        input logic [4:0] rs1, input logic [4:0] rs2,
                                        input logic [12:0] imm);
        return {op, rd, rs1, rs2, imm};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_count(input int exp, input string tag);
        chk(log_n == exp, tag, 32'(log_n), 32'(exp));
    endtask

    task automatic chk_entry(input int idx, input logic [31:0] pc, input logic [31:0] ins, input string tag);
        chk(log_pc[idx] == pc, tag, log_pc[idx], pc);
        chk(log_ins[idx] == ins, tag, log_ins[idx], ins);
    endtask

    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3, input string tag);
        int guard = 0;
        while (!fetch_req_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(fetch_req_valid == 1'b1, tag, 32'(fetch_req_valid), 32'd1);
        chk(fetch_req_addr == exp_addr, tag, fetch_req_addr, exp_addr);
        fetch_rsp_valid = 1'b1;
        fetch_rsp_line  = {w3, w2, w1, w0};
        @(negedge clk);
        fetch_rsp_valid = 1'b0;
        fetch_rsp_line  = '0;
    endtask

    task automatic wb_pulse(input logic v0, input logic [4:0] r0, input logic v1, input logic [4:0] r1);
        wb0_valid = v0; wb0_reg = r0;
        wb1_valid = v1; wb1_reg = r1;
        @(negedge clk);
        wb0_valid = 1'b0; wb1_valid = 1'b0;
        wb0_reg = '0; wb1_reg = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        rst_pc = 32'h0000_0104;
        wait_cyc(3);
        chk(iss_valid == 1'b0, "R1 iss_valid in reset", 32'(iss_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_req_valid == 1'b1, "R1 request after reset", 32'(fetch_req_valid), 32'd1);
        chk(fetch_req_addr == 32'h100, "R1 aligned reset address", fetch_req_addr, 32'h100);
        wait_cyc(4);
        chk(iss_valid == 1'b0, "R4 no issue while buffer empty", 32'(iss_valid), 32'd0);
        chk(fetch_req_addr == 32'h100, "R2 request address held", fetch_req_addr, 32'h100);
        chk_count(0, "R4 nothing issued before line");
    endtask

    task automatic t_seq_line();
        serve(32'h100, enc(4'd1, 5'd1, 5'd0, 5'd0, 13'd0), enc(4'd1, 5'd10, 5'd0, 5'd0, 13'd0),
              enc(4'd2, 5'd11, 5'd0, 5'd0, 13'd5), enc(4'd3, 5'd0, 5'd0, 5'd0, 13'd0), "R2 first line");
        wait_cyc(8);
        chk_count(3, "R1 start at reset word offset");
        chk_entry(0, 32'h104, enc(4'd1, 5'd10, 5'd0, 5'd0, 13'd0), "R1 first issued word");
        chk_entry(1, 32'h108, enc(4'd2, 5'd11, 5'd0, 5'd0, 13'd5), "R3 second issued word");
        chk_entry(2, 32'h10C, enc(4'd3, 5'd0, 5'd0, 5'd0, 13'd0), "R11 store-type word issued");
        chk(fetch_req_addr == 32'h110, "R3 next sequential line", fetch_req_addr, 32'h110);
    endtask

    task automatic t_branch();
        serve(32'h110, enc(4'd1, 5'd12, 5'd0, 5'd0, 13'd0), enc(4'd4, 5'd0, 5'd0, 5'd0, 13'd61),
              enc(4'd1, 5'd20, 5'd0, 5'd0, 13'd0), enc(4'd1, 5'd21, 5'd0, 5'd0, 13'd0), "R9 branch line");
        serve(32'h200, enc(4'd1, 5'd22, 5'd0, 5'd0, 13'd0), enc(4'd1, 5'd23, 5'd0, 5'd0, 13'd0),
              enc(4'd1, 5'd13, 5'd0, 5'd0, 13'd0), enc(4'd4, 5'd0, 5'd0, 5'd0, 13'(-66)), "R9 forward target line");
        wait_cyc(6);
        chk_count(5, "R9 jumps and skipped words not issued");
        chk_entry(3, 32'h110, enc(4'd1, 5'd12, 5'd0, 5'd0, 13'd0), "R9 word before jump");
        chk_entry(4, 32'h208, enc(4'd1, 5'd13, 5'd0, 5'd0, 13'd0), "R9 decode at target offset");
        chk(fetch_req_addr == 32'h100, "R9 backward jump line", fetch_req_addr, 32'h100);
    endtask

    task automatic t_raw();
        serve(32'h100, enc(4'd1, 5'd24, 5'd0, 5'd0, 13'd0), enc(4'd1, 5'd3, 5'd1, 5'd2, 13'd0),
              enc(4'd1, 5'd4, 5'd3, 5'd0, 13'd0), enc(4'd1, 5'd8, 5'd0, 5'd0, 13'd0), "R9 backward target line");
        wait_cyc(6);
        chk_count(6, "R5 dependent word waits");
        chk_entry(5, 32'h104, enc(4'd1, 5'd3, 5'd1, 5'd2, 13'd0), "R9 backward target offset");
        chk(fetch_req_valid == 1'b0, "R5 no request during stall", 32'(fetch_req_valid), 32'd0);
        wb_pulse(1'b1, 5'd9, 1'b0, 5'd0);
        wait_cyc(4);
        chk_count(6, "R6 unrelated writeback keeps stall");
        wb_pulse(1'b0, 5'd0, 1'b1, 5'd3);
        wait_cyc(6);
        chk_count(8, "R6 port 1 writeback releases");
        chk_entry(6, 32'h108, enc(4'd1, 5'd4, 5'd3, 5'd0, 13'd0), "R5 dependent issued first");
        chk_entry(7, 32'h10C, enc(4'd1, 5'd8, 5'd0, 5'd0, 13'd0), "R5 younger issued after");
    endtask

    task automatic t_dual_wb();
        serve(32'h110, enc(4'd1, 5'd5, 5'd0, 5'd0, 13'd0), enc(4'd1, 5'd6, 5'd0, 5'd0, 13'd0),
              enc(4'd3, 5'd0, 5'd5, 5'd6, 13'd0), enc(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), "R3 sequential line");
        wait_cyc(6);
        chk_count(10, "R6 store waits on two pending");
        wb_pulse(1'b1, 5'd5, 1'b1, 5'd6);
        wait_cyc(6);
        chk_count(12, "R6 dual writeback same cycle");
        chk_entry(10, 32'h118, enc(4'd3, 5'd0, 5'd5, 5'd6, 13'd0), "R6 store issued");
        chk_entry(11, 32'h11C, enc(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), "R11 other opcode issued");
    endtask

    task automatic t_collision();
        serve(32'h120, enc(4'd1, 5'd7, 5'd0, 5'd0, 13'd0), enc(4'd2, 5'd9, 5'd7, 5'd0, 13'd1),
              enc(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), enc(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), "R3 collision line");
        wb_pulse(1'b1, 5'd7, 1'b0, 5'd0);
        wait_cyc(5);
        chk_count(13, "R7 set wins over same-edge clear");
        wb_pulse(1'b0, 5'd0, 1'b1, 5'd7);
        wait_cyc(6);
        chk_count(16, "R7 later clear releases");
        chk_entry(13, 32'h124, enc(4'd2, 5'd9, 5'd7, 5'd0, 13'd1), "R7 dependent after clear");
    endtask

    task automatic t_backpressure();
        iss_ready = 1'b0;
        serve(32'h130, enc(4'd1, 5'd0, 5'd1, 5'd2, 13'd0), enc(4'd1, 5'd14, 5'd0, 5'd0, 13'd0),
              enc(4'd2, 5'd15, 5'd0, 5'd0, 13'd0), enc(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), "R3 backpressure line");
        wait_cyc(5);
        chk(iss_valid == 1'b1, "R10 entry held", 32'(iss_valid), 32'd1);
        chk(iss_pc == 32'h130, "R10 held pc", iss_pc, 32'h130);
        chk(iss_instr == enc(4'd1, 5'd0, 5'd1, 5'd2, 13'd0), "R10 held word", iss_instr,
            enc(4'd1, 5'd0, 5'd1, 5'd2, 13'd0));
        wait_cyc(3);
        chk(iss_pc == 32'h130, "R10 held pc stable", iss_pc, 32'h130);
        chk(fetch_req_valid == 1'b0, "R10 decode stalled, no request", 32'(fetch_req_valid), 32'd0);
        chk_count(16, "R10 nothing accepted while not ready");
        iss_ready = 1'b1;
        wait_cyc(8);
        chk_count(20, "R8 read of r0 not stalled after write of r0");
        chk_entry(16, 32'h130, enc(4'd1, 5'd0, 5'd1, 5'd2, 13'd0), "R10 held entry delivered");
        chk_entry(17, 32'h134, enc(4'd1, 5'd14, 5'd0, 5'd0, 13'd0), "R8 r0 reader issued");
        chk(fetch_req_addr == 32'h140, "R3 line after drain", fetch_req_addr, 32'h140);
    endtask

    initial begin
        rst = 1'b1;
        rst_pc = 32'h104;
        fetch_rsp_valid = 1'b0;
        fetch_rsp_line = '0;
        iss_ready = 1'b1;
        wb0_valid = 1'b0; wb0_reg = '0;
        wb1_valid = 1'b0; wb1_reg = '0;
        @(negedge clk);
        t_reset();
        t_seq_line();
        t_branch();
        t_raw();
        t_dual_wb();
        t_collision();
        t_backpressure();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule